// File: doc/BRIEF.md
# Queue status interrupt aggregator

This block turns the status flags of 64 queues into two interrupt lines for a processor. The lower group, queues 0 to 31, presents four flags per queue: empty, nearly-empty, nearly-full and full. A 4-bit trigger-select field per queue picks one of these flags, or its inverse, as that queue's trigger condition. The upper group, queues 32 to 63, presents only a nearly-empty flag and a full flag, and its trigger is always the nearly-empty flag.

A queue records a pending bit when its trigger condition goes from false to true while its enable bit is set. Each group has an enable register, a pending register and an interrupt line that is the OR of that group's pending bits. Software reads the pending register, handles the queues, and writes the same value back to clear exactly the bits it has seen. The block also lets software read the raw queue flags. The queue storage is outside the block, and the flags arrive as inputs.

The register bus is a single-cycle write strobe with a combinational read path. Word addresses are: 0-3 trigger-select, 4-7 lower status, 8 lower enable, 9 upper enable, 10 lower pending, 11 upper pending, 12 upper nearly-empty flags, 13 upper full flags. Other addresses read as zero and ignore writes.

Top module: `qstat_irq_agg`

## Requirements
- R1: After reset, every trigger-select, enable and pending register reads zero, and irq_lo and irq_hi are low.
- R2: Lower queue q's flags are lo_status[4q+3:4q], with bit 0 empty, bit 1 nearly-empty, bit 2 nearly-full and bit 3 full. Trigger codes 0, 1, 2 and 3 select empty, nearly-empty, nearly-full and full. A false-to-true change of the selected flag while enable bit q is 1 sets lower pending bit q at the next clock edge. A change of any other flag of that queue sets nothing.
- R3: Trigger codes 4 to 7 select the inverse of the flag that code minus 4 selects: not-empty, not-nearly-empty, not-nearly-full and not-full. A pending bit is set when the selected flag falls.
- R4: A trigger edge that occurs while the queue's enable bit is 0 sets no pending bit. Setting the enable bit while the condition is already true, with no new edge, sets nothing.
- R5: Upper queue 32+n sets upper pending bit n on a rising edge of hi_ne[n] while upper enable bit n is 1. The hi_full input never sets a pending bit.
- R6: Writing to a pending register clears each bit that has a 1 in the write data and leaves the bits that have a 0.
- R7: If a new trigger edge and a clearing write hit the same pending bit in the same cycle, the bit is set afterwards.
- R8: irq_lo is high exactly when some lower pending bit is 1, and irq_hi is high exactly when some upper pending bit is 1. The two lines are independent.
- R9: Address 4+w reads lo_status[32w+31:32w] for w from 0 to 3. Address 12 reads hi_ne, and address 13 reads hi_full.
- R10: Queue q's trigger-select field is bits [4(q mod 8)+3 : 4(q mod 8)] of the register at address q/8. All 4 bits are stored and read back. Bit 3 of a field does not change the trigger, so code c acts as code c mod 8.
- R11: A condition that stays true sets its pending bit only once. After that bit is cleared, it stays clear until a new false-to-true edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_status | input | 128 | Four flags per lower queue, queue q at bits 4q+3:4q |
| hi_ne | input | 32 | Nearly-empty flags of upper queues, queue 32+n at bit n |
| hi_full | input | 32 | Full flags of upper queues, queue 32+n at bit n |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| irq_lo | output | 1 | Lower group interrupt |
| irq_hi | output | 1 | Upper group interrupt |

## Verification
The hardest case to reach is the one where a new trigger edge and a clearing write land on the same pending bit in the same cycle. The bench first lets the condition settle false. It then drives the rising flag and the clearing bus write in one cycle, so that both meet at a single clock edge. Reprogramming a trigger code can also create or hide an edge. For that reason, each trigger code is tested only after the queue's flags have been set to make the new condition false, and the pending register has been cleared before the real edge is driven.

// File: rtl/qstat_irq_agg.sv
module qstat_irq_agg #(
  parameter int QN = 32,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4*QN-1:0] lo_status,
  input  logic [QN-1:0]   hi_ne,
  input  logic [QN-1:0]   hi_full,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [QN-1:0]   bus_wdata,
  output logic [QN-1:0]   bus_rdata,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int NW      = QN / 8;
  localparam int A_SEL   = 0;
  localparam int A_STAT  = NW;
  localparam int A_EN_LO = 2 * NW;
  localparam int A_EN_HI = 2 * NW + 1;
  localparam int A_PD_LO = 2 * NW + 2;
  localparam int A_PD_HI = 2 * NW + 3;
  localparam int A_NE    = 2 * NW + 4;
  localparam int A_FULL  = 2 * NW + 5;

  logic [4*QN-1:0] sel_q;
  logic [QN-1:0] en_lo, en_hi, pd_lo, pd_hi;
  logic [QN-1:0] cond_lo, cond_lo_q, ne_q;
  logic [QN-1:0] rise_lo, rise_hi, clr_lo, clr_hi;

  for (genvar q = 0; q < QN; q++) begin : g_cond
    logic [3:0] s, st;
    assign s  = sel_q[4*q +: 4];
    assign st = lo_status[4*q +: 4];
    assign cond_lo[q] = s[2] ^ st[s[1:0]];
  end

  assign rise_lo = cond_lo & ~cond_lo_q;
  assign rise_hi = hi_ne & ~ne_q;

  assign clr_lo = (bus_we && bus_addr == AW'(A_PD_LO)) ? bus_wdata : '0;
  assign clr_hi = (bus_we && bus_addr == AW'(A_PD_HI)) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      en_lo     <= '0;
      en_hi     <= '0;
      pd_lo     <= '0;
      pd_hi     <= '0;
      cond_lo_q <= '0;
      ne_q      <= '0;
    end else begin
      cond_lo_q <= cond_lo;
      ne_q      <= hi_ne;
      pd_lo     <= (pd_lo & ~clr_lo) | (rise_lo & en_lo);
      pd_hi     <= (pd_hi & ~clr_hi) | (rise_hi & en_hi);
      if (bus_we) begin
        for (int i = 0; i < NW; i++)
          if (bus_addr == AW'(A_SEL + i)) sel_q[i*QN +: QN] <= bus_wdata;
        if (bus_addr == AW'(A_EN_LO)) en_lo <= bus_wdata;
        if (bus_addr == AW'(A_EN_HI)) en_hi <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NW; i++) begin
      if (bus_addr == AW'(A_SEL + i))  bus_rdata = sel_q[i*QN +: QN];
      if (bus_addr == AW'(A_STAT + i)) bus_rdata = lo_status[i*QN +: QN];
    end
    if (bus_addr == AW'(A_EN_LO)) bus_rdata = en_lo;
    if (bus_addr == AW'(A_EN_HI)) bus_rdata = en_hi;
    if (bus_addr == AW'(A_PD_LO)) bus_rdata = pd_lo;
    if (bus_addr == AW'(A_PD_HI)) bus_rdata = pd_hi;
    if (bus_addr == AW'(A_NE))    bus_rdata = hi_ne;
    if (bus_addr == AW'(A_FULL))  bus_rdata = hi_full;
  end

  assign irq_lo = |pd_lo;
  assign irq_hi = |pd_hi;
endmodule

// File: rtl/qstat_irq_agg_chk.sv
module qstat_irq_agg_chk #(
  parameter int QN = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [QN-1:0] bus_wdata,
  input logic [QN-1:0] hi_ne,
  input logic [QN-1:0] en_lo,
  input logic [QN-1:0] en_hi,
  input logic [QN-1:0] pd_lo,
  input logic [QN-1:0] pd_hi,
  input logic [QN-1:0] rise_lo,
  input logic          irq_hi
);
  localparam int A_PD_LO = 2 * (QN / 8) + 2;
  logic          wr_pd_lo;
  logic [QN-1:0] wmask;
  assign wr_pd_lo = bus_we && bus_addr == AW'(A_PD_LO);
  assign wmask    = wr_pd_lo ? bus_wdata : '0;

  p_set_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pd_lo & ~$past(pd_lo) & ~$past(en_lo)) == '0));

  p_hi_set_on_ne_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pd_hi & ~$past(pd_hi) & ~($past(hi_ne) & ~$past(hi_ne, 2) & $past(en_hi))) == '0));

  p_pending_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pd_lo) & ~pd_lo & ~$past(wmask)) == '0));

  p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pd_lo |=> ((pd_lo & $past(bus_wdata) & ~$past(rise_lo & en_lo)) == '0));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_lo & en_lo) & ~pd_lo) == '0));

  p_irq_hi_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_hi) |-> ($past(en_hi) != '0));
endmodule

bind qstat_irq_agg qstat_irq_agg_chk #(.QN(QN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .hi_ne(hi_ne), .en_lo(en_lo), .en_hi(en_hi),
  .pd_lo(pd_lo), .pd_hi(pd_hi), .rise_lo(rise_lo), .irq_hi(irq_hi)
);

// File: tb/test_qstat_irq_agg.sv
module test_qstat_irq_agg;
  localparam logic [3:0] SEL0 = 0, STAT0 = 4, EN_LO = 8, EN_HI = 9;
  localparam logic [3:0] PD_LO = 10, PD_HI = 11, NEW = 12, FULLW = 13;

  logic clk = 0, rst_n = 0;
  logic [127:0] lo_status = '0;
  logic [31:0] hi_ne = '0, hi_full = '0;
  logic bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_lo, irq_hi;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qstat_irq_agg i_qstat_irq_agg (
    .clk(clk), .rst_n(rst_n), .lo_status(lo_status), .hi_ne(hi_ne),
    .hi_full(hi_full), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic nib(int q, logic [3:0] v);
    lo_status[4*q +: 4] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 4; a++) begin rd(SEL0 + 4'(a), d); chk("R1 sel", d, 0); end
    rd(EN_LO, d); chk("R1 en_lo", d, 0);
    rd(EN_HI, d); chk("R1 en_hi", d, 0);
    rd(PD_LO, d); chk("R1 pd_lo", d, 0);
    rd(PD_HI, d); chk("R1 pd_hi", d, 0);
    chk("R1 irq", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    lo_status = 128'h0123_4567_89AB_CDEF_1357_9BDF_2468_ACE0;
    hi_ne = 32'hA5A5_0F0F; hi_full = 32'h3C3C_F00F;
    for (int w = 0; w < 4; w++) begin
      rd(STAT0 + 4'(w), d); chk("R9 lo word", d, lo_status[32*w +: 32]);
    end
    rd(NEW, d);   chk("R9 ne word", d, 32'hA5A5_0F0F);
    rd(FULLW, d); chk("R9 full word", d, 32'h3C3C_F00F);
    lo_status = '0; hi_ne = '0; hi_full = '0;
    tick();
  endtask

  task automatic t_selpack;
    logic [31:0] d;
    wr(SEL0 + 1, 32'h7654_3210); rd(SEL0 + 1, d); chk("R10 sel1", d, 32'h7654_3210);
    wr(SEL0 + 2, 32'hFEDC_BA98); rd(SEL0 + 2, d); chk("R10 sel2", d, 32'hFEDC_BA98);
    wr(EN_LO, 32'h1 << 20);
    nib(20, 4'h1); tick();
    nib(20, 4'h0); tick();
    rd(PD_LO, d); chk("R10 code C acts as not-empty", d, 32'h1 << 20);
    wr(EN_LO, 0); wr(SEL0 + 1, 0); wr(SEL0 + 2, 0); wr(PD_LO, 32'hFFFF_FFFF);
    rd(PD_LO, d); chk("R10 cleanup", d, 0);
  endtask

  task automatic t_codes;
    logic [31:0] d;
    logic [3:0] fv, tv;
    for (int c = 0; c < 8; c++) begin
      fv = (c >= 4) ? (4'h1 << (c % 4)) : 4'h0;
      nib(9, fv); tick();
      wr(SEL0 + 1, 32'(c) << 4);
      wr(EN_LO, 32'h1 << 9);
      wr(PD_LO, 32'hFFFF_FFFF);
      fv = fv ^ (4'h1 << ((c + 1) % 4));
      nib(9, fv); tick();
      rd(PD_LO, d); chk((c < 4) ? "R2 other flag ignored" : "R3 other flag ignored", d, 0);
      tv = fv ^ (4'h1 << (c % 4));
      nib(9, tv); tick();
      rd(PD_LO, d); chk((c < 4) ? "R2 selected edge sets" : "R3 inverse edge sets", d, 32'h1 << 9);
      chk("R8 irq_lo on", {31'd0, irq_lo}, 1);
      wr(PD_LO, 32'h1 << 9);
      tick(); tick();
      rd(PD_LO, d); chk("R11 held condition no reassert", d, 0);
    end
    wr(EN_LO, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    nib(3, 4'h1); tick();
    rd(PD_LO, d); chk("R4 disabled edge", d, 0);
    wr(EN_LO, 32'h1 << 3); tick(); tick();
    rd(PD_LO, d); chk("R4 enable on held condition", d, 0);
    nib(3, 4'h0); tick();
    nib(3, 4'h1); tick();
    rd(PD_LO, d); chk("R4 enabled edge", d, 32'h1 << 3);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    wr(EN_LO, (32'h1 << 3) | (32'h1 << 9));
    nib(9, 4'h8); tick();
    nib(9, 4'h0); tick();
    rd(PD_LO, d); chk("R6 two pending", d, (32'h1 << 3) | (32'h1 << 9));
    wr(PD_LO, 32'h1 << 3);
    rd(PD_LO, d); chk("R6 one cleared", d, 32'h1 << 9);
    wr(PD_LO, 0);
    rd(PD_LO, d); chk("R6 zero write keeps", d, 32'h1 << 9);
    wr(PD_LO, 32'h1 << 9);
    rd(PD_LO, d); chk("R6 all cleared", d, 0);
    chk("R8 irq_lo off", {31'd0, irq_lo}, 0);
  endtask

  task automatic t_setwins;
    logic [31:0] d;
    nib(3, 4'h0); tick();
    nib(3, 4'h1);
    bus_we = 1; bus_addr = PD_LO; bus_wdata = 32'h1 << 3;
    tick();
    bus_we = 0;
    rd(PD_LO, d); chk("R7 set beats clear", d, 32'h1 << 3);
    wr(PD_LO, 32'hFFFF_FFFF); wr(EN_LO, 0);
  endtask

  task automatic t_hi;
    logic [31:0] d;
    wr(EN_HI, 32'h1 << 5);
    hi_full[5] = 1; tick();
    rd(PD_HI, d); chk("R5 full ignored", d, 0);
    hi_ne[6] = 1; tick();
    rd(PD_HI, d); chk("R5 disabled queue", d, 0);
    hi_ne[5] = 1; tick();
    rd(PD_HI, d); chk("R5 ne edge sets", d, 32'h1 << 5);
    chk("R8 irq_hi on, irq_lo off", {30'd0, irq_hi, irq_lo}, 2'b10);
    wr(PD_HI, 32'h1 << 5);
    chk("R8 irq_hi off", {31'd0, irq_hi}, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_status();
    t_selpack();
    t_codes();
    t_enable();
    t_w1c();
    t_setwins();
    t_hi();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule